// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns asynchronous serial frames on one input line into parallel characters. It does not divide a clock itself. A clock-enable tick at sixteen times the baud rate paces every sampling decision, and the rest of the chip supplies that tick. Each frame has a low start bit, five to eight data bits sent least significant bit first, an optional parity bit and a high stop bit. Configuration inputs set the word length and the parity options. The block latches them when a start bit is accepted, so they may change between frames without corrupting the frame in progress.

A falling edge on the idle line opens a candidate start bit. The block confirms it only if the line stays low for eight consecutive ticks, which is half a bit time, and this rejects short glitches. After that, each bit is sampled sixteen ticks after the one before, so every sample falls near the middle of its bit. A shift register collects the character. At the middle of the stop bit the character moves into a holding register, together with its parity and framing status. The receiver then starts hunting for the next start edge at once, without waiting for the end of the stop bit. A host reads the holding register and pulses a read strobe, which clears the ready indication and the error flags.

The controller has five named states:
- IDLE: waits for a high-to-low step on the line.
- START: counts low ticks.
- DATA: samples the data bits.
- PARITY: samples the parity bit.
- STOP: samples the stop bit.

Its transitions are:
- edge-seen (IDLE to START)
- glitch-reject (START to IDLE)
- start-confirmed (START to DATA)
- last-data with parity (DATA to PARITY)
- last-data without parity (DATA to STOP)
- parity-taken (PARITY to STOP)
- stop-taken (STOP to IDLE)

Top module: `serial_rx_core`

## Requirements
- R1: The receiver changes state only in clock cycles where `tick_en` is high. With `tick_en` held low, no character is ever delivered. A tick every third clock receives the same characters as a tick on every clock.
- R2: A low level lasting fewer than 8 ticks after a falling edge is discarded and no character results. A low level of exactly 8 ticks is accepted as a start bit.
- R3: After the start bit is accepted, data bits are sampled 16 ticks apart and placed least significant bit first into `rx_data`.
- R4: `cfg_len` picks the word length. Codes 0, 1, 2 and 3 mean 5, 6, 7 and 8 data bits. Bits of `rx_data` above the word length read as zero.
- R5: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd`=1 demands an odd count of ones over data plus parity, and 0 demands an even count. A mismatch sets `parity_err`. When `cfg_par_en` is 0, no parity bit is expected and `parity_err` stays 0.
- R6: A low level sampled at the stop-bit middle sets `frame_err`, and the character is still delivered.
- R7: Hunting for the next start edge resumes right after the stop-bit middle is sampled. A frame whose stop bit lasts only 12 ticks, followed at once by another frame, yields both characters.
- R8: After reset, `data_ready`=0, `ready_n`=1, `rx_data`=0 and all error flags are 0. A completed character sets `data_ready` and drives `ready_n` low.
- R9: A one-cycle `rd_stb` clears `data_ready`, `parity_err`, `frame_err` and `overrun_err`, and `ready_n` returns high.
- R10: A character that completes while `data_ready` is still set overwrites `rx_data` and sets `overrun_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Sampling enable pulse at 16x baud |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Word length code, 5 + code bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_stb | input | 1 | Host has read the character |
| rx_data | output | 8 | Held character, right aligned |
| data_ready | output | 1 | A character is waiting |
| ready_n | output | 1 | Active-low copy of the waiting indication |
| parity_err | output | 1 | Parity mismatch on the held character |
| frame_err | output | 1 | Stop bit sampled low |
| overrun_err | output | 1 | An unread character was overwritten |

## Verification
The assertions check on every cycle these rules:
- The controller stays frozen between ticks.
- A high sample during start qualification returns it to IDLE.
- The ready flag rises only right after a commit.
- A read empties the buffer.
- Overwriting an unread character raises the overrun flag.
- Bits above the word length stay clear.

Only the bench's scenarios can show the following:
- Characters come out with the right value and bit order for every word length and parity setting.
- Parity errors are detected correctly.
- The eight-tick boundary of glitch rejection holds.
- The early resume at the stop-bit middle lets a shortened stop bit pass.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= line_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], line_async};
            end
        end
    endgenerate

    assign line_sync = chain[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8,
    parameter int MIN_BITS   = 5,
    parameter int LEN_W      = $clog2(DATA_W - MIN_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    output rx_state_t        state,
    output logic [LEN_W-1:0] len_q,
    output logic             par_en_q,
    output logic             par_odd_q,
    output logic             start_ok,
    output logic             bit_stb,
    output logic             par_stb,
    output logic             stop_stb
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int HALF  = OVERSAMPLE / 2;
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);

    rx_state_t        nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [BIT_W-1:0] bit_idx, nxt_bit_idx;
    logic             prev_lvl, nxt_prev_lvl;
    logic [BIT_W-1:0] last_idx;

    assign last_idx = BIT_W'(MIN_BITS - 1) + BIT_W'(len_q);

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            prev_lvl  <= 1'b1;
            len_q     <= '0;
            par_en_q  <= 1'b0;
            par_odd_q <= 1'b0;
        end else begin
            state    <= nxt_state;
            cnt      <= nxt_cnt;
            bit_idx  <= nxt_bit_idx;
            prev_lvl <= nxt_prev_lvl;
            if (start_ok) begin
                len_q     <= cfg_len;
                par_en_q  <= cfg_par_en;
                par_odd_q <= cfg_par_odd;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt_state    = state;
        nxt_cnt      = cnt;
        nxt_bit_idx  = bit_idx;
        nxt_prev_lvl = prev_lvl;
        if (tick) begin
            nxt_prev_lvl = line;
            unique case (state)
                ST_IDLE: begin
                    // edge-seen
                    if (prev_lvl && !line) begin
                        nxt_state = ST_START;
                        nxt_cnt   = CNT_W'(1);
                    end
                end
                ST_START: begin
                    if (line) begin
                        // glitch-reject
                        nxt_state = ST_IDLE;
                        nxt_cnt   = '0;
                    end else if (cnt == CNT_HALF) begin
                        // start-confirmed
                        nxt_state   = ST_DATA;
                        nxt_cnt     = '0;
                        nxt_bit_idx = '0;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == CNT_LAST) begin
                        nxt_cnt = '0;
                        if (bit_idx == last_idx)
                            nxt_state = par_en_q ? ST_PARITY : ST_STOP;
                        else
                            nxt_bit_idx = bit_idx + 1'b1;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (cnt == CNT_LAST) begin
                        // parity-taken
                        nxt_state = ST_STOP;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == CNT_LAST) begin
                        // stop-taken: hunt again from the stop-bit middle
                        nxt_state = ST_IDLE;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // strobes toward the datapath
    always_comb begin
        start_ok = tick && (state == ST_START) && !line && (cnt == CNT_HALF);
        bit_stb  = tick && (state == ST_DATA)   && (cnt == CNT_LAST);
        par_stb  = tick && (state == ST_PARITY) && (cnt == CNT_LAST);
        stop_stb = tick && (state == ST_STOP)   && (cnt == CNT_LAST);
    end

endmodule

// File: rtl/rx_char_assembler.sv
module rx_char_assembler #(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int LEN_W    = $clog2(DATA_W - MIN_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              start_ok,
    input  logic              bit_stb,
    input  logic              par_stb,
    input  logic [LEN_W-1:0]  len_q,
    input  logic              par_en_q,
    input  logic              par_odd_q,
    output logic [DATA_W-1:0] char_out,
    output logic              par_bad
);

    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] shreg;
    logic              ones_acc;
    logic              par_bit_q;
    logic [SH_W-1:0]   nbits;
    logic [SH_W-1:0]   align;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            ones_acc  <= 1'b0;
            par_bit_q <= 1'b0;
        end else begin
            if (start_ok) begin
                shreg     <= '0;
                ones_acc  <= 1'b0;
                par_bit_q <= 1'b0;
            end else if (bit_stb) begin
                shreg    <= {line, shreg[DATA_W-1:1]};
                ones_acc <= ones_acc ^ line;
            end else if (par_stb) begin
                par_bit_q <= line;
            end
        end
    end

    always_comb begin
        nbits    = SH_W'(MIN_BITS) + SH_W'(len_q);
        align    = SH_W'(DATA_W) - nbits;
        char_out = shreg >> align;
        par_bad  = par_en_q && (ones_acc ^ par_bit_q ^ par_odd_q);
    end

endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] char_in,
    input  logic              par_bad,
    input  logic              stop_low,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              perr_q,
    output logic              ferr_q,
    output logic              ovr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (commit) begin
            data_q  <= char_in;
            ready_q <= 1'b1;
            perr_q  <= par_bad;
            ferr_q  <= stop_low;
            ovr_q   <= (ovr_q || ready_q) && !rd_stb;
        end else if (rd_stb) begin
            ready_q <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_W      = 8,
    parameter int MIN_BITS    = 5,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = $clog2(DATA_W - MIN_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rx_in,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              ready_n,
    output logic              parity_err,
    output logic              frame_err,
    output logic              overrun_err
);

    logic              line_s;
    rx_state_t         fsm_state;
    logic [LEN_W-1:0]  len_q;
    logic              par_en_q, par_odd_q;
    logic              start_ok, bit_stb, par_stb, stop_stb;
    logic [DATA_W-1:0] char_w;
    logic              par_bad;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_async(rx_in), .line_sync(line_s)
    );

    rx_frame_fsm #(
        .OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .line(line_s),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .state(fsm_state), .len_q(len_q), .par_en_q(par_en_q), .par_odd_q(par_odd_q),
        .start_ok(start_ok), .bit_stb(bit_stb), .par_stb(par_stb), .stop_stb(stop_stb)
    );

    rx_char_assembler #(
        .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
    ) u_asm (
        .clk(clk), .rst_n(rst_n), .line(line_s), .start_ok(start_ok),
        .bit_stb(bit_stb), .par_stb(par_stb), .len_q(len_q),
        .par_en_q(par_en_q), .par_odd_q(par_odd_q),
        .char_out(char_w), .par_bad(par_bad)
    );

    rx_hold_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .commit(stop_stb), .char_in(char_w),
        .par_bad(par_bad), .stop_low(!line_s), .rd_stb(rd_stb),
        .data_q(rx_data), .ready_q(data_ready), .perr_q(parity_err),
        .ferr_q(frame_err), .ovr_q(overrun_err)
    );

    assign ready_n = !data_ready;

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk
    import serial_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int LEN_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              line_s,
    input rx_state_t         fsm_state,
    input logic              stop_stb,
    input logic              rd_stb,
    input logic              data_ready,
    input logic              overrun_err,
    input logic [DATA_W-1:0] rx_data,
    input logic [LEN_W-1:0]  len_q
);

    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] above_len;
    always_comb above_len = rx_data >> (SH_W'(MIN_BITS) + SH_W'(len_q));

    a_r1_frozen_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(fsm_state));

    a_r2_glitch_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_START && tick_en && line_s) |=> (fsm_state == ST_IDLE));

    a_r4_upper_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |=> (above_len == '0));

    a_r8_ready_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(stop_stb));

    a_r9_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !stop_stb) |=> !data_ready);

    a_r10_overwrite_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && data_ready && !rd_stb) |=> overrun_err);

endmodule

bind serial_rx_core serial_rx_core_chk #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .line_s(line_s),
    .fsm_state(fsm_state), .stop_stb(stop_stb), .rd_stb(rd_stb),
    .data_ready(data_ready), .overrun_err(overrun_err), .rx_data(rx_data),
    .len_q(len_q)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, ready_n, parity_err, frame_err, overrun_err;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tcnt = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) begin
        if (tick_div == 0 || tcnt >= tick_div - 1) tcnt <= 0;
        else tcnt <= tcnt + 1;
    end
    assign tick_en = (tick_div != 0) && (tcnt == 0);

    serial_rx_core dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_stb(rd_stb), .rx_data(rx_data), .data_ready(data_ready),
        .ready_n(ready_n), .parity_err(parity_err), .frame_err(frame_err),
        .overrun_err(overrun_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_ticks(input logic lvl, input int nticks);
        rx_in = lvl;
        repeat (nticks * ((tick_div == 0) ? 1 : tick_div)) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                              input bit badpar, input bit stop_lvl, input int stop_ticks);
        logic pbit;
        cfg_len     = 2'(nb - 5);
        cfg_par_en  = pen;
        cfg_par_odd = podd;
        pbit = podd;
        hold_ticks(1'b0, 16);
        for (int i = 0; i < nb; i++) begin
            pbit = pbit ^ d[i];
            hold_ticks(d[i], 16);
        end
        if (pen) hold_ticks(pbit ^ badpar, 16);
        hold_ticks(stop_lvl, stop_ticks);
        rx_in = 1'b1;
    endtask

    task automatic do_read();
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
    endtask

    task automatic check_cleared(input string req);
        chk(!data_ready && ready_n, req, {data_ready, ready_n}, 2'b01);
        chk(!parity_err && !frame_err && !overrun_err, req,
            {parity_err, frame_err, overrun_err}, 3'b000);
    endtask

    task automatic sweep_frame(input logic [7:0] d, input int nb, input bit pen, input bit podd, input bit bad);
        logic [7:0] exp_d;
        exp_d = d & 8'((1 << nb) - 1);
        send_frame(d, nb, pen, podd, bad, 1'b1, 16);
        hold_ticks(1'b1, 4);
        chk(rx_data == exp_d, "R3 R4 data", rx_data, exp_d);
        chk(data_ready && !ready_n, "R8 ready", {data_ready, ready_n}, 2'b10);
        chk(parity_err == (pen & bad), "R5 parity", parity_err, pen & bad);
        chk(!frame_err && !overrun_err, "R6 R10 no error", {frame_err, overrun_err}, 2'b00);
        do_read();
        check_cleared("R9 read clears");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(rx_data == 8'h00, "R8 reset data", rx_data, 0);
        check_cleared("R8 reset flags");

        // R3 R4 R5 exhaustive configuration sweep, tick every clock
        for (int nb = 5; nb <= 8; nb++)
            for (int pc = 0; pc < 4; pc++)
                for (int k = 0; k < 8; k++)
                    sweep_frame(8'((k * 8'h53) ^ (k[0] ? 8'hA5 : 8'h18)), nb, pc[1], pc[0], k[1]);

        // R1 tick every third clock gives the same result
        tick_div = 3;
        for (int nb = 5; nb <= 8; nb++)
            for (int k = 0; k < 3; k++)
                sweep_frame(8'(8'hC6 + k * 8'h2B), nb, k[0], k[1], k[0]);

        // R1 no ticks: nothing is received
        tick_div = 0;
        send_frame(8'h0F, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16);
        hold_ticks(1'b1, 20);
        chk(!data_ready, "R1 frozen without tick", data_ready, 0);
        tick_div = 1;
        hold_ticks(1'b1, 40);
        chk(!data_ready, "R1 idle after tick resumes", data_ready, 0);

        // R2 glitch of 7 ticks rejected
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        hold_ticks(1'b0, 7);
        hold_ticks(1'b1, 200);
        chk(!data_ready, "R2 short low rejected", data_ready, 0);
        // R2 exactly 8 ticks accepted, data bits then read as ones
        hold_ticks(1'b0, 8);
        hold_ticks(1'b1, 200);
        chk(data_ready && rx_data == 8'hFF, "R2 eight ticks accepted", {data_ready, rx_data}, 9'h1FF);
        do_read();

        // R6 framing error keeps character
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
        hold_ticks(1'b1, 32);
        chk(frame_err, "R6 frame error", frame_err, 1);
        chk(rx_data == 8'h3C && data_ready, "R6 char delivered", {data_ready, rx_data}, 9'h13C);
        do_read();
        check_cleared("R9 after framing");

        // R10 overrun
        send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16);
        hold_ticks(1'b1, 4);
        send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16);
        hold_ticks(1'b1, 4);
        chk(overrun_err, "R10 overrun set", overrun_err, 1);
        chk(rx_data == 8'h22, "R10 overwritten", rx_data, 8'h22);
        do_read();
        check_cleared("R9 after overrun");

        // R7 shortened stop bit then immediate next frame
        send_frame(8'h5A, 8, 1'b1, 1'b0, 1'b0, 1'b1, 12);
        send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16);
        hold_ticks(1'b1, 4);
        chk(rx_data == 8'hC3, "R7 second frame data", rx_data, 8'hC3);
        chk(overrun_err && data_ready, "R7 both frames received", {overrun_err, data_ready}, 2'b11);
        do_read();
        check_cleared("R9 after resume");

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule